// File: doc/BRIEF.md
# Operand-Wakeup Instruction Queue

This block holds instructions after dispatch and releases them to a single execution unit once both operands are known. Each dispatched instruction carries an operation code, the tag its result will be known by, and two source fields. A source field arrives either with its value already filled in or with the tag of the instruction that will produce it. Tag zero is reserved to mean that the value is already present.

A finishing producer drives a tag and a result value on a shared result bus. Every occupied slot compares that tag against both of its waiting sources in the same cycle. Every matching source takes the value, so several waiting instructions can wake from a single broadcast. A broadcast in the same cycle as the dispatch that names its tag is taken by the new slot on the way in.

Among the ready slots, the one dispatched earliest is issued. Each slot stores its rank in dispatch order, so issue follows operand readiness and not program order. The issued slot is freed at the same clock edge. A full flag refuses dispatch, and a flush input empties the pool in one cycle.

Top module: `rs_pool`

## Requirements
- R1: After reset no slot is occupied: `full` is 0 and `iss_vld` is 0.
- R2: A source tag of 0 at dispatch means the accompanying value is used as the operand. A nonzero tag means the source waits for a broadcast carrying that tag.
- R3: A slot is offered for issue only when both of its sources hold values. `iss_vld` becomes 1 in the cycle after the last source becomes available.
- R4: When `bus_vld` is 1 with a nonzero `bus_tag`, every waiting source of every occupied slot whose tag equals `bus_tag` takes `bus_val` at that edge. This covers both sources of a slot and several slots at once.
- R5: When a dispatch names a source tag equal to a `bus_tag` that is broadcast in the same cycle, the new slot stores `bus_val` for that source and does not wait.
- R6: When several slots are ready, the one dispatched earliest issues. A younger ready slot issues ahead of an older waiting one. Age order holds even when a younger instruction refills a lower-numbered free slot.
- R7: `full` is 1 when all 8 slots are occupied. A dispatch presented while `full` is 1 is dropped.
- R8: A slot that is offered on the issue outputs is released at that clock edge, so `full` drops in the next cycle.
- R9: `flush` empties every slot at the next edge. A dispatch presented in the flush cycle is dropped, and later broadcasts wake nothing.
- R10: A bus cycle with `bus_vld` at 0, or with `bus_tag` equal to 0, wakes no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all slots at the next edge |
| disp_vld | input | 1 | Dispatch request |
| disp_op | input | 4 | Operation code of the dispatched instruction |
| disp_dtag | input | 4 | Result tag of the dispatched instruction |
| disp_tag1 | input | 4 | First source producer tag (0 = value present) |
| disp_val1 | input | 32 | First source value |
| disp_tag2 | input | 4 | Second source producer tag (0 = value present) |
| disp_val2 | input | 32 | Second source value |
| full | output | 1 | All slots occupied; dispatch refused |
| bus_vld | input | 1 | Result bus carries a broadcast |
| bus_tag | input | 4 | Tag of the broadcast result |
| bus_val | input | 32 | Value of the broadcast result |
| iss_vld | output | 1 | An instruction is offered to the execution unit |
| iss_op | output | 4 | Operation code of the issued instruction |
| iss_dtag | output | 4 | Result tag of the issued instruction |
| iss_opa | output | 32 | First operand of the issued instruction |
| iss_opb | output | 32 | Second operand of the issued instruction |

## Verification
The pool is first filled to capacity with eight instructions, each waiting on its own tag. Broadcasts then arrive in reverse tag order, which shows that issue order follows wakeup order and that each release reopens dispatch. A single tag is then broadcast to three waiters that use the first source, the second source and both sources. This separates parallel capture from one-at-a-time capture, and distinguishes the first source from the second. An issue-then-refill sequence places a young instruction in a lower-numbered slot than an older one, which separates age order from slot-index order. Further patterns cover the same-cycle bypass at dispatch, broadcasts with a mismatching tag, with tag zero or with the valid bit low, and a flush that arrives together with a dispatch.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // What a source field does at the next edge.
  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_DISP = 2'd1,
    SRC_BUS  = 2'd2
  } src_act_e;

  // Dispatch loads the slot; a same-cycle bus hit overrides the dispatched
  // value. An occupied waiting source takes the bus value on a tag hit.
  function automatic src_act_e src_action(input logic alloc,
                                          input logic in_hit,
                                          input logic held_hit);
    if (alloc) return in_hit ? SRC_BUS : SRC_DISP;
    return held_hit ? SRC_BUS : SRC_KEEP;
  endfunction

endpackage

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
#(
  parameter int DW = 32,
  parameter int TW = 4,
  parameter int OW = 4,
  parameter int AW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                alloc,
  input  logic [AW-1:0]       alloc_age,
  input  logic [OW-1:0]       in_op,
  input  logic [TW-1:0]       in_dtag,
  input  logic [1:0][TW-1:0]  in_tag,
  input  logic [1:0][DW-1:0]  in_val,
  input  logic                bus_vld,
  input  logic [TW-1:0]       bus_tag,
  input  logic [DW-1:0]       bus_val,
  input  logic                grant,
  input  logic                free_fire,
  input  logic [AW-1:0]       free_age,
  output logic                valid,
  output logic                ready,
  output logic [AW-1:0]       age,
  output logic [OW-1:0]       op,
  output logic [TW-1:0]       dtag,
  output logic [DW-1:0]       opa,
  output logic [DW-1:0]       opb,
  output logic [1:0]          woke
);

  logic          valid_q;
  logic [AW-1:0] age_q;
  logic [OW-1:0] op_q;
  logic [TW-1:0] dtag_q;
  logic [TW-1:0] tag_w [2];
  logic [DW-1:0] val_w [2];

  for (genvar s = 0; s < 2; s++) begin : g_src
    logic [TW-1:0] t_q;
    logic [DW-1:0] v_q;
    logic          in_hit;
    logic          held_hit;
    src_act_e      act;

    assign in_hit   = bus_vld && (in_tag[s] != '0) && (bus_tag == in_tag[s]);
    assign held_hit = valid_q && bus_vld && (t_q != '0) && (bus_tag == t_q);
    assign act      = src_action(alloc, in_hit, held_hit);
    assign woke[s]  = (act == SRC_BUS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_q <= '0;
        v_q <= '0;
      end else begin
        case (act)
          SRC_DISP: begin
            t_q <= in_tag[s];
            v_q <= in_val[s];
          end
          SRC_BUS: begin
            t_q <= '0;
            v_q <= bus_val;
          end
          default: ;
        endcase
      end
    end

    assign tag_w[s] = t_q;
    assign val_w[s] = v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      age_q   <= '0;
      op_q    <= '0;
      dtag_q  <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (alloc) begin
      valid_q <= 1'b1;
      age_q   <= alloc_age;
      op_q    <= in_op;
      dtag_q  <= in_dtag;
    end else if (grant) begin
      valid_q <= 1'b0;
    end else if (valid_q && free_fire && (age_q > free_age)) begin
      age_q <= age_q - AW'(1);
    end
  end

  assign valid = valid_q;
  assign ready = valid_q && (tag_w[0] == '0) && (tag_w[1] == '0);
  assign age   = age_q;
  assign op    = op_q;
  assign dtag  = dtag_q;
  assign opa   = val_w[0];
  assign opb   = val_w[1];

endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic [N-1:0]    ready,
  input  logic [N*AW-1:0] ages,
  output logic [N-1:0]    grant
);

  localparam int IW = $clog2(N);

  logic          found;
  logic [AW-1:0] best_age;
  logic [IW-1:0] best_idx;

  always_comb begin
    grant    = '0;
    found    = 1'b0;
    best_age = '0;
    best_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (ready[i] && (!found || (ages[i*AW +: AW] < best_age))) begin
        found    = 1'b1;
        best_age = ages[i*AW +: AW];
        best_idx = IW'(i);
      end
    end
    if (found) grant[best_idx] = 1'b1;
  end

endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4,
  parameter int OP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              disp_vld,
  input  logic [OP_W-1:0]   disp_op,
  input  logic [TAG_W-1:0]  disp_dtag,
  input  logic [TAG_W-1:0]  disp_tag1,
  input  logic [DATA_W-1:0] disp_val1,
  input  logic [TAG_W-1:0]  disp_tag2,
  input  logic [DATA_W-1:0] disp_val2,
  output logic              full,
  input  logic              bus_vld,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_val,
  output logic              iss_vld,
  output logic [OP_W-1:0]   iss_op,
  output logic [TAG_W-1:0]  iss_dtag,
  output logic [DATA_W-1:0] iss_opa,
  output logic [DATA_W-1:0] iss_opb
);

  localparam int AGE_W = $clog2(ENTRIES);

  // Named internal events, also used by the bound checker.
  logic [ENTRIES-1:0]       valid_vec;
  logic [ENTRIES-1:0]       ready_vec;
  logic [ENTRIES-1:0]       grant_vec;
  logic [ENTRIES-1:0]       alloc_vec;
  logic [2*ENTRIES-1:0]     wake_vec;
  logic [ENTRIES*AGE_W-1:0] age_flat;

  logic [OP_W-1:0]   e_op   [ENTRIES];
  logic [TAG_W-1:0]  e_dtag [ENTRIES];
  logic [DATA_W-1:0] e_opa  [ENTRIES];
  logic [DATA_W-1:0] e_opb  [ENTRIES];
  logic [AGE_W-1:0]  e_age  [ENTRIES];

  logic              alloc_ok;
  logic [AGE_W-1:0]  alloc_age;
  logic [AGE_W-1:0]  free_age;

  // One-hot mask of the lowest-numbered empty slot.
  function automatic logic [ENTRIES-1:0] lowest_free(input logic [ENTRIES-1:0] v);
    logic [ENTRIES-1:0] m;
    m = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!v[i]) begin
        m    = '0;
        m[i] = 1'b1;
      end
    end
    return m;
  endfunction

  // Slots that stay occupied past this edge; a newcomer ranks after them.
  function automatic logic [AGE_W-1:0] live_count(input logic [ENTRIES-1:0] v,
                                                 input logic [ENTRIES-1:0] g);
    logic [AGE_W-1:0] n;
    n = '0;
    for (int i = 0; i < ENTRIES; i++) n = n + AGE_W'(v[i] & ~g[i]);
    return n;
  endfunction

  assign full      = &valid_vec;
  assign alloc_ok  = disp_vld && !full && !flush;
  assign alloc_vec = alloc_ok ? lowest_free(valid_vec) : '0;
  assign alloc_age = live_count(valid_vec, grant_vec);
  assign iss_vld   = |grant_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    rs_slot #(
      .DW(DATA_W), .TW(TAG_W), .OW(OP_W), .AW(AGE_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .alloc     (alloc_vec[i]),
      .alloc_age (alloc_age),
      .in_op     (disp_op),
      .in_dtag   (disp_dtag),
      .in_tag    ({disp_tag2, disp_tag1}),
      .in_val    ({disp_val2, disp_val1}),
      .bus_vld   (bus_vld),
      .bus_tag   (bus_tag),
      .bus_val   (bus_val),
      .grant     (grant_vec[i]),
      .free_fire (iss_vld),
      .free_age  (free_age),
      .valid     (valid_vec[i]),
      .ready     (ready_vec[i]),
      .age       (e_age[i]),
      .op        (e_op[i]),
      .dtag      (e_dtag[i]),
      .opa       (e_opa[i]),
      .opb       (e_opb[i]),
      .woke      (wake_vec[2*i +: 2])
    );
    assign age_flat[i*AGE_W +: AGE_W] = e_age[i];
  end

  rs_pick #(.N(ENTRIES), .AW(AGE_W)) u_pick (
    .ready (ready_vec),
    .ages  (age_flat),
    .grant (grant_vec)
  );

  always_comb begin
    iss_op   = '0;
    iss_dtag = '0;
    iss_opa  = '0;
    iss_opb  = '0;
    free_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant_vec[i]) begin
        iss_op   = iss_op   | e_op[i];
        iss_dtag = iss_dtag | e_dtag[i];
        iss_opa  = iss_opa  | e_opa[i];
        iss_opb  = iss_opb  | e_opb[i];
        free_age = free_age | e_age[i];
      end
    end
  end

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N  = 8,
  parameter int TW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           flush,
  input logic           bus_vld,
  input logic [TW-1:0]  bus_tag,
  input logic           full,
  input logic           iss_vld,
  input logic [N-1:0]   valid_vec,
  input logic [N-1:0]   ready_vec,
  input logic [N-1:0]   grant_vec,
  input logic [N-1:0]   alloc_vec,
  input logic [2*N-1:0] wake_vec
);

  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> (valid_vec == '0));

  a_r3_grant_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_vec & ~ready_vec) == '0));

  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  a_r6_issue_has_grant: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld |-> ($countones(grant_vec) == 1));

  a_r7_full_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (alloc_vec == '0));

  a_r8_issued_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0) |=> ((valid_vec & $past(grant_vec)) == '0));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  a_r10_wake_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_vec != '0) |-> (bus_vld && (bus_tag != '0)));

endmodule

bind rs_pool rs_pool_chk #(.N(ENTRIES), .TW(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .bus_vld   (bus_vld),
  .bus_tag   (bus_tag),
  .full      (full),
  .iss_vld   (iss_vld),
  .valid_vec (valid_vec),
  .ready_vec (ready_vec),
  .grant_vec (grant_vec),
  .alloc_vec (alloc_vec),
  .wake_vec  (wake_vec)
);

// File: tb/tb_rs_pool.sv
`timescale 1ns/1ps
module tb_rs_pool;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        disp_vld;
  logic [3:0]  disp_op, disp_dtag, disp_tag1, disp_tag2;
  logic [31:0] disp_val1, disp_val2;
  logic        full;
  logic        bus_vld;
  logic [3:0]  bus_tag;
  logic [31:0] bus_val;
  logic        iss_vld;
  logic [3:0]  iss_op, iss_dtag;
  logic [31:0] iss_opa, iss_opb;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rs_pool dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_vld(disp_vld), .disp_op(disp_op), .disp_dtag(disp_dtag),
    .disp_tag1(disp_tag1), .disp_val1(disp_val1),
    .disp_tag2(disp_tag2), .disp_val2(disp_val2),
    .full(full),
    .bus_vld(bus_vld), .bus_tag(bus_tag), .bus_val(bus_val),
    .iss_vld(iss_vld), .iss_op(iss_op), .iss_dtag(iss_dtag),
    .iss_opa(iss_opa), .iss_opb(iss_opb)
  );

  // Bench-side operand values.
  function automatic logic [31:0] va(input int k);
    return 32'hA000_0000 + 32'(k) * 32'h0001_0101;
  endfunction
  function automatic logic [31:0] vb(input int k);
    return 32'h5000_0000 + 32'(k) * 32'h0003_0007;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    flush = 0; disp_vld = 0; disp_op = 0; disp_dtag = 0;
    disp_tag1 = 0; disp_val1 = 0; disp_tag2 = 0; disp_val2 = 0;
    bus_vld = 0; bus_tag = 0; bus_val = 0;
  endtask

  task automatic disp(input logic [3:0] op, input logic [3:0] dt,
                      input logic [3:0] t1, input logic [31:0] v1,
                      input logic [3:0] t2, input logic [31:0] v2);
    disp_vld = 1; disp_op = op; disp_dtag = dt;
    disp_tag1 = t1; disp_val1 = v1; disp_tag2 = t2; disp_val2 = v2;
  endtask

  task automatic bc(input logic [3:0] t, input logic [31:0] v);
    bus_vld = 1; bus_tag = t; bus_val = v;
  endtask

  task automatic cyc();
    @(posedge clk); #1; clr();
  endtask

  task automatic exp_iss(input string req, input logic [3:0] op,
                         input logic [3:0] dt, input logic [31:0] a,
                         input logic [31:0] b);
    chk(req, "iss_vld", 32'(iss_vld), 32'd1);
    chk(req, "iss_dtag", 32'(iss_dtag), 32'(dt));
    chk(req, "iss_op", 32'(iss_op), 32'(op));
    chk(req, "iss_opa", iss_opa, a);
    chk(req, "iss_opb", iss_opb, b);
  endtask

  task automatic exp_idle(input string req);
    chk(req, "iss_vld", 32'(iss_vld), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; clr();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "full", 32'(full), 32'd0);
    exp_idle("R1");
    rst_n = 1;
    cyc();

    // R2 / R3: operands present at dispatch, issue next cycle, then freed.
    disp(4'd3, 4'd5, 4'd0, va(1), 4'd0, vb(1)); cyc();
    exp_iss("R2", 4'd3, 4'd5, va(1), vb(1));
    cyc();
    exp_idle("R8");

    // R10 then R4: no wake on invalid or zero-tag bus, wake on match.
    disp(4'd1, 4'd6, 4'd4, 32'hDEAD_0000, 4'd0, vb(2)); cyc();
    exp_idle("R3");
    bus_vld = 0; bus_tag = 4'd4; bus_val = va(9); cyc();
    exp_idle("R10");
    bc(4'd0, va(8)); cyc();
    exp_idle("R10");
    bc(4'd3, va(7)); cyc();
    exp_idle("R4");
    bc(4'd4, va(4)); cyc();
    exp_iss("R4", 4'd1, 4'd6, va(4), vb(2));
    cyc();
    exp_idle("R8");

    // R4: one broadcast wakes three waiters across both sources.
    disp(4'd2, 4'd1, 4'd0, va(11), 4'd7, 32'h0); cyc();
    disp(4'd4, 4'd2, 4'd7, 32'h0, 4'd0, vb(12)); cyc();
    disp(4'd6, 4'd3, 4'd7, 32'h0, 4'd7, 32'h0); cyc();
    exp_idle("R3");
    bc(4'd7, 32'h7777_1234); cyc();
    exp_iss("R4", 4'd2, 4'd1, va(11), 32'h7777_1234);
    cyc();
    exp_iss("R4", 4'd4, 4'd2, 32'h7777_1234, vb(12));
    cyc();
    exp_iss("R4", 4'd6, 4'd3, 32'h7777_1234, 32'h7777_1234);
    cyc();
    exp_idle("R8");

    // R5: broadcast in the dispatch cycle is taken by the new slot.
    disp(4'd9, 4'd8, 4'd0, va(20), 4'd6, 32'hBAD0_BAD0);
    bc(4'd6, 32'h6666_0006); cyc();
    exp_iss("R5", 4'd9, 4'd8, va(20), 32'h6666_0006);
    cyc();

    // R6: younger ready instruction overtakes an older waiting one.
    disp(4'd1, 4'd10, 4'd9, 32'h0, 4'd0, vb(30)); cyc();
    disp(4'd2, 4'd11, 4'd0, va(31), 4'd0, vb(31)); cyc();
    exp_iss("R6", 4'd2, 4'd11, va(31), vb(31));
    bc(4'd9, va(32)); cyc();
    exp_iss("R6", 4'd1, 4'd10, va(32), vb(30));
    cyc();
    exp_idle("R8");

    // R6: age order, not slot order, after a younger refill of a hole.
    disp(4'd1, 4'd1, 4'd11, 32'h0, 4'd0, vb(41)); cyc();
    disp(4'd2, 4'd2, 4'd0, va(42), 4'd0, vb(42)); cyc();
    exp_iss("R6", 4'd2, 4'd2, va(42), vb(42));
    disp(4'd3, 4'd3, 4'd11, 32'h0, 4'd0, vb(43)); cyc();
    exp_idle("R6");
    disp(4'd4, 4'd4, 4'd11, 32'h0, 4'd0, vb(44)); cyc();
    bc(4'd11, va(40)); cyc();
    exp_iss("R6", 4'd1, 4'd1, va(40), vb(41));
    cyc();
    exp_iss("R6", 4'd3, 4'd3, va(40), vb(43));
    cyc();
    exp_iss("R6", 4'd4, 4'd4, va(40), vb(44));
    cyc();
    exp_idle("R8");

    // R7 / R8: fill all 8 slots, refuse a dispatch, drain in reverse wake order.
    for (int i = 0; i < 8; i++) begin
      disp(4'(i), 4'(i), 4'(i + 1), 32'h0, 4'd0, vb(i));
      cyc();
    end
    chk("R7", "full", 32'(full), 32'd1);
    disp(4'd15, 4'd12, 4'd0, va(50), 4'd0, vb(50)); cyc();
    exp_idle("R7");
    chk("R7", "full", 32'(full), 32'd1);
    for (int t = 8; t >= 1; t--) begin
      bc(4'(t), va(t)); cyc();
      exp_iss("R6", 4'(t - 1), 4'(t - 1), va(t), vb(t - 1));
      chk("R8", "full", 32'(full), (t == 8) ? 32'd1 : 32'd0);
    end
    cyc();
    exp_idle("R7");

    // R9: flush empties the pool and drops a same-cycle dispatch.
    disp(4'd1, 4'd1, 4'd10, 32'h0, 4'd0, vb(60)); cyc();
    disp(4'd2, 4'd2, 4'd0, va(61), 4'd10, 32'h0); cyc();
    disp(4'd3, 4'd13, 4'd0, va(62), 4'd0, vb(62));
    flush = 1; cyc();
    exp_idle("R9");
    chk("R9", "full", 32'(full), 32'd0);
    bc(4'd10, va(63)); cyc();
    exp_idle("R9");
    cyc();
    exp_idle("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule